// File: doc/BRIEF.md
# Command Coalescing Script Packer

The packer takes typed commands, each an opcode plus zero to four 32-bit argument words, and turns them into a compact word stream for a script memory. Commands that arrive back to back with the same opcode share one packet: a single header word that gives the payload length and the opcode, followed by the argument words of all merged commands in arrival order.

A packet leaves the block when a command with a different opcode arrives, when the next command would fill the merge buffer, when software pulses `flush`, or straight after any opcode whose consumer can only handle one instance per packet. While a packet is being emitted the command input is stalled. The output is a valid/ready stream of 32-bit words. The words must hold still while the stream is stalled.

Top module: `cmd_packer`

## Requirements
- R1: A header word carries the payload word count in bits 31:16 and the opcode zero-extended in bits 15:0. Argument lane k of `cmd_args` occupies bits 32k+31:32k, and lanes 0 to `cmd_nargs`-1 follow the header in lane order and command order, one word per output beat. Words stay stable while `out_ready` is low.
- R2: Consecutive commands with the same opcode and no intervening packet boundary are merged into one packet whose count is the sum of their argument counts.
- R3: A command whose opcode differs from the pending opcode first causes the pending packet to be emitted. The new command then starts a fresh packet.
- R4: If the pending count plus the incoming argument count would be 64 or more, the pending packet is emitted first. No packet ever carries more than 63 payload words.
- R5: Opcodes WAIT=2 (four arguments), DELAY=3 (one) and VBLANK=4 (one) are emitted immediately after being appended, so each forms a packet of its own. WR32=1 takes two arguments.
- R6: Zero-argument opcodes TRAIN=5, ENTER=6 and LEAVE=7 become pending and yield a header with count zero. Consecutive identical ones merge into that single header.
- R7: A one-cycle `flush` pulse emits the pending packet. With nothing pending, it emits nothing.
- R8: A command with opcode 0 is consumed and discarded. It does not change the pending packet.
- R9: `cmd_ready` is low in every cycle in which `out_valid` is high.
- R10: After reset, `out_valid` is low, `cmd_ready` is high and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when high with valid |
| cmd_op | input | 8 | Command opcode (0 reserved) |
| cmd_nargs | input | 3 | Number of argument words, 0 to 4 |
| cmd_args | input | 128 | Argument lanes, lane k in bits 32k+31:32k |
| flush | input | 1 | Emit the pending packet |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 32 | Header or payload word |

## Verification
A wrong pending opcode or count shows at the ports on the very next header word. That header carries a wrong count or opcode, or a packet boundary appears where the command order did not call for one. A buffer indexing fault shows as a payload word out of order within the same packet. A state machine stuck in emission would keep `cmd_ready` low or repeat words, and the word-by-word scoreboard catches this at the first surplus or missing beat. The scoreboard predicts every packet from the command sequence alone, so any misplaced boundary is reported on the first word that differs.

// File: rtl/cmdpk_pkg.sv
package cmdpk_pkg;
  localparam int OP_W   = 8;
  localparam int WORD_W = 32;

  typedef enum logic [OP_W-1:0] {
    OP_NONE   = 8'd0,
    OP_WR32   = 8'd1,
    OP_WAIT   = 8'd2,
    OP_DELAY  = 8'd3,
    OP_VBLANK = 8'd4,
    OP_TRAIN  = 8'd5,
    OP_ENTER  = 8'd6,
    OP_LEAVE  = 8'd7
  } op_e;

  // opcodes the consumer can only take one per packet
  function automatic logic is_solo(input logic [OP_W-1:0] op);
    return (op == OP_WAIT) || (op == OP_DELAY) || (op == OP_VBLANK);
  endfunction

  function automatic logic [WORD_W-1:0] hdr_word(input logic [15:0] cnt,
                                                 input logic [OP_W-1:0] op);
    return {cnt, {(16-OP_W){1'b0}}, op};
  endfunction
endpackage

// File: rtl/cmdpk_buf.sv
module cmdpk_buf #(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int NW   = $clog2(LANES + 1)
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_base,
  input  logic [NW-1:0]        wr_n,
  input  logic [LANES*W-1:0]   wr_data,
  input  logic [AW-1:0]        rd_addr,
  output logic [W-1:0]         rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int k = 0; k < LANES; k++) begin
        if (k < int'(wr_n))
          mem[AW'(int'(wr_base) + k)] <= wr_data[k*W +: W];
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/cmdpk_ctrl.sv
module cmdpk_ctrl
  import cmdpk_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int MAX_ARGS = 4,
  localparam int CNT_W   = $clog2(DEPTH),
  localparam int NW      = $clog2(MAX_ARGS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [OP_W-1:0]  cmd_op,
  input  logic [NW-1:0]    cmd_nargs,
  input  logic             flush,
  input  logic             out_ready,
  output logic             cmd_ready,
  output logic             out_valid,
  output logic             hdr_sel,
  output logic [CNT_W-1:0] rd_idx,
  output logic [OP_W-1:0]  pend_op,
  output logic [CNT_W-1:0] pend_cnt,
  output logic             ev_append,
  output logic             ev_start,
  output logic             ev_done,
  output logic             ev_discard
);
  typedef enum logic {S_IDLE, S_EMIT} st_e;
  st_e             st;
  logic [CNT_W-1:0] beat_idx;
  logic [CNT_W:0]   sum;
  logic             idle, clash, hold;

  always_comb begin
    idle       = (st == S_IDLE);
    sum        = {1'b0, pend_cnt} + (CNT_W+1)'(cmd_nargs);
    clash      = (pend_op != OP_NONE) &&
                 ((cmd_op != pend_op) || (int'(sum) >= DEPTH));
    ev_discard = idle && !flush && cmd_valid && (cmd_op == OP_NONE);
    hold       = idle && !flush && cmd_valid && (cmd_op != OP_NONE) && clash;
    cmd_ready  = idle && !flush && !hold;
    ev_append  = cmd_ready && cmd_valid && (cmd_op != OP_NONE);
    ev_start   = (idle && flush && (pend_op != OP_NONE)) || hold;
    out_valid  = (st == S_EMIT);
    ev_done    = out_valid && out_ready && (beat_idx == pend_cnt);
    hdr_sel    = (beat_idx == '0);
    rd_idx     = beat_idx - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      beat_idx <= '0;
      pend_op  <= OP_NONE;
      pend_cnt <= '0;
    end else begin
      if (ev_append) begin
        pend_op  <= cmd_op;
        pend_cnt <= sum[CNT_W-1:0];
        if (is_solo(cmd_op)) begin
          st       <= S_EMIT;
          beat_idx <= '0;
        end
      end
      if (ev_start) begin
        st       <= S_EMIT;
        beat_idx <= '0;
      end
      if (out_valid && out_ready) begin
        if (ev_done) begin
          st       <= S_IDLE;
          pend_op  <= OP_NONE;
          pend_cnt <= '0;
        end else begin
          beat_idx <= beat_idx + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/cmd_packer.sv
module cmd_packer
  import cmdpk_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int MAX_ARGS = 4,
  localparam int CNT_W   = $clog2(DEPTH),
  localparam int NW      = $clog2(MAX_ARGS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic [OP_W-1:0]            cmd_op,
  input  logic [NW-1:0]              cmd_nargs,
  input  logic [MAX_ARGS*WORD_W-1:0] cmd_args,
  input  logic                       flush,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [WORD_W-1:0]          out_data
);
  logic             hdr_sel;
  logic [CNT_W-1:0] rd_idx;
  logic [OP_W-1:0]  pend_op;
  logic [CNT_W-1:0] pend_cnt;
  logic             ev_append, ev_start, ev_done, ev_discard;
  logic [WORD_W-1:0] rd_data;

  cmdpk_ctrl #(.DEPTH(DEPTH), .MAX_ARGS(MAX_ARGS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_nargs(cmd_nargs), .flush(flush), .out_ready(out_ready),
    .cmd_ready(cmd_ready), .out_valid(out_valid), .hdr_sel(hdr_sel),
    .rd_idx(rd_idx), .pend_op(pend_op), .pend_cnt(pend_cnt),
    .ev_append(ev_append), .ev_start(ev_start), .ev_done(ev_done),
    .ev_discard(ev_discard)
  );

  cmdpk_buf #(.DEPTH(DEPTH), .LANES(MAX_ARGS), .W(WORD_W)) u_buf (
    .clk(clk), .wr_en(ev_append), .wr_base(pend_cnt), .wr_n(cmd_nargs),
    .wr_data(cmd_args), .rd_addr(rd_idx), .rd_data(rd_data)
  );

  assign out_data = hdr_sel ? hdr_word(16'(pend_cnt), pend_op) : rd_data;
endmodule

// File: rtl/cmdpk_chk.sv
module cmdpk_chk
  import cmdpk_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [OP_W-1:0]   cmd_op,
  input logic              flush,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic [OP_W-1:0]   pend_op,
  input logic              ev_append
);
  // R9
  input_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !cmd_ready);

  // R1
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R4
  hdr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (int'(out_data[31:16]) < DEPTH));

  // R5
  solo_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_append && is_solo(cmd_op)) |=> out_valid);

  // R3
  same_op_append_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_append && pend_op != OP_NONE) |-> (cmd_op == pend_op));

  // R7
  empty_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && pend_op == OP_NONE && !out_valid) |=> !out_valid);

  // R8
  discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == OP_NONE) |=> $stable(pend_op));

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!out_valid && pend_op == OP_NONE));
endmodule

bind cmd_packer cmdpk_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/cmd_packer_test.sv
module cmd_packer_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [7:0]   cmd_op = '0;
  logic [2:0]   cmd_nargs = '0;
  logic [127:0] cmd_args = '0;
  logic         flush = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [31:0]  out_data;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  logic [31:0] exp_q[$];
  logic [7:0]  m_op = 8'd0;
  logic [31:0] m_words[$];
  int rdy_cnt = 0;
  int cycles = 0;

  cmd_packer uut (.*);

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  function automatic void model_emit();
    if (m_op != 8'd0) begin
      exp_q.push_back({16'(m_words.size()), 8'd0, m_op});
      foreach (m_words[i]) exp_q.push_back(m_words[i]);
      m_words.delete();
      m_op = 8'd0;
    end
  endfunction

  function automatic bit solo(input logic [7:0] op);
    return op == 8'd2 || op == 8'd3 || op == 8'd4;
  endfunction

  task automatic send(input logic [7:0] op, input int n, input logic [31:0] a0,
                      input logic [31:0] a1, input logic [31:0] a2, input logic [31:0] a3);
    if (op != 8'd0) begin
      if (m_op != 8'd0 && (op != m_op || m_words.size() + n >= 64)) model_emit();
      if (n > 0) m_words.push_back(a0);
      if (n > 1) m_words.push_back(a1);
      if (n > 2) m_words.push_back(a2);
      if (n > 3) m_words.push_back(a3);
      m_op = op;
      if (solo(op)) model_emit();
    end
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_nargs = 3'(n);
    cmd_args = {a3, a2, a1, a0};
    #1;
    while (!cmd_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic do_flush();
    model_emit();
    @(negedge clk);
    flush = 1'b1;
    @(posedge clk);
    #1 flush = 1'b0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0 && !out_valid, req, "packets not fully emitted",
          32'(exp_q.size()), 32'd0);
  endtask

  // monitor: scoreboard pop and compare on every beat
  always @(negedge clk) begin
    rdy_cnt++;
    out_ready <= (rdy_cnt % 5) != 3;
    #1;
    if (rst_n && out_valid) begin
      check(!cmd_ready, "R9", "ready high during emission", 32'(cmd_ready), 32'd0);
      if (out_ready) begin
        if (exp_q.size() == 0)
          check(1'b0, cur_req, "unexpected word", out_data, 32'hxxxxxxxx);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check(out_data === e, cur_req, "word mismatch", out_data, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    // R10
    check(!out_valid, "R10", "out_valid after reset", 32'(out_valid), 32'd0);
    check(cmd_ready, "R10", "cmd_ready after reset", 32'(cmd_ready), 32'd1);

    // R1, R2: three WR32 merge into one six-word packet
    cur_req = "R2";
    send(8'd1, 2, 32'hA0000001, 32'h11110001, 0, 0);
    send(8'd1, 2, 32'hA0000002, 32'h11110002, 0, 0);
    send(8'd1, 2, 32'hA0000003, 32'h11110003, 0, 0);
    do_flush();
    drain("R2");

    // R3: opcode changes force boundaries
    cur_req = "R3";
    send(8'd1, 2, 32'hB0000001, 32'h22220001, 0, 0);
    send(8'd5, 0, 0, 0, 0, 0);
    send(8'd6, 0, 0, 0, 0, 0);
    send(8'd1, 2, 32'hB0000002, 32'h22220002, 0, 0);
    do_flush();
    drain("R3");

    // R5: solo opcodes each form their own packet without a flush
    cur_req = "R5";
    send(8'd2, 4, 32'hC0000001, 32'hFFFF0000, 32'h00001234, 32'd1000);
    send(8'd2, 4, 32'hC0000002, 32'h0000FFFF, 32'h00005678, 32'd2000);
    send(8'd3, 1, 32'd500, 0, 0, 0);
    send(8'd4, 1, 32'd1, 0, 0, 0);
    send(8'd1, 2, 32'hC0000003, 32'h33330003, 0, 0);
    send(8'd2, 4, 32'hC0000004, 32'h000000FF, 32'h00000011, 32'd30);
    drain("R5");

    // R6: zero-argument commands
    cur_req = "R6";
    send(8'd5, 0, 0, 0, 0, 0);
    send(8'd5, 0, 0, 0, 0, 0);
    do_flush();
    send(8'd7, 0, 0, 0, 0, 0);
    do_flush();
    drain("R6");

    // R4: capacity boundary, 31 WR32 = 62 words, the 32nd would reach 64
    cur_req = "R4";
    for (int i = 0; i < 32; i++)
      send(8'd1, 2, 32'hD0000000 + 32'(i), 32'h44440000 + 32'(i), 0, 0);
    do_flush();
    drain("R4");

    // R8: reserved opcode is dropped, WR32s still merge
    cur_req = "R8";
    send(8'd1, 2, 32'hE0000001, 32'h55550001, 0, 0);
    send(8'd0, 3, 32'hDEAD0000, 32'hDEAD0001, 32'hDEAD0002, 0);
    send(8'd1, 2, 32'hE0000002, 32'h55550002, 0, 0);
    do_flush();
    drain("R8");

    // R7: flush with nothing pending emits nothing
    cur_req = "R7";
    do_flush();
    do_flush();
    repeat (5) @(negedge clk);
    #2;
    check(!out_valid, "R7", "output after empty flush", 32'(out_valid), 32'd0);
    send(8'd3, 1, 32'd77, 0, 0, 0);
    do_flush();
    drain("R7");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule